// File: doc/BRIEF.md
# Set-Indexed PLRU Victim Selector

This block holds the tree pseudo-LRU replacement state for every set of a set-associative data cache and chooses the way to evict when a line must be allocated. The surrounding cache reports registered hits, as a set and a way, and raises an allocate request when a miss needs a line. One cycle after that request a choose-victim flag is raised internally. In that cycle the block reads the set's tree, captures the way the tree points at into the victim register, and writes back a tree that marks that way as most recently used.

The write happens at the same clock edge as the capture, so the capture always sees the old tree. The way being refilled is protected at once. Two misses to one set therefore evict different ways, even when the first refill has not finished.

Top module: `plru_victim_sel`

## Requirements
- R1: Each set has its own tree of WAYS-1 bits, selected by the set index. An update to one set leaves the victim choice of every other set unchanged.
- R2: A synchronous active-high reset clears every tree and the victim register to zero, so the first victim in any set is way 0.
- R3: When `miss_req` is sampled high at a clock edge, the choose-victim flag is high for the next cycle only. The new victim appears on `victim_way` after the following edge, two edges after the request was sampled.
- R4: The captured victim comes from the tree as it was before the write made at the capture edge.
- R5: At the capture edge the set's tree is rewritten so that the captured way becomes most recently used.
- R6: A `hit_vld` pulse rewrites the tree of `hit_set` so that `hit_way` becomes most recently used. A hit must never fall in a choose-victim cycle; if it does, the hit update wins.
- R7: Tree nodes are numbered heap-style: root 0, children of node n at 2n+1 and 2n+2. A 0 bit points to the lower half of the ways. The victim is found by walking from the root along the bits, with the way number built MSB first. An update sets each node on the used way's path to point away from it.
- R8: Two misses in a row to the same set, back to back or separated by idle cycles, select different victim ways.
- R9: A way that was refilled and then hit while the cache is idle is not the next victim chosen in that set.
- R10: `victim_way` changes only at a capture edge and holds its value through hits and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_vld | input | 1 | Registered cache hit pulse |
| hit_set | input | $clog2(SETS) | Set of the hit |
| hit_way | input | $clog2(WAYS) | Way of the hit |
| miss_req | input | 1 | Miss needing a line allocation |
| miss_set | input | $clog2(SETS) | Set of the miss |
| victim_way | output | $clog2(WAYS) | Registered victim way |

## Verification
The bench targets back-to-back misses to one set. A design that captured after the update, or that left the tree untouched on allocation, would return the same way twice or the wrong first way. It also runs a miss, a hit on the refilled way, then another miss, which shows whether a hit really protects a way. Misses to an untouched set after heavy traffic elsewhere expose set-index aliasing. A capture one cycle early or late shows up against the cycle-accurate model, as does a victim output that moves on hits.

// File: rtl/plru_victim_sel.sv
module plru_victim_sel #(
  parameter int WAYS = 4,
  parameter int SETS = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hit_vld,
  input  logic [$clog2(SETS)-1:0] hit_set,
  input  logic [$clog2(WAYS)-1:0] hit_way,
  input  logic                    miss_req,
  input  logic [$clog2(SETS)-1:0] miss_set,
  output logic [$clog2(WAYS)-1:0] victim_way
);
  localparam int WW    = $clog2(WAYS);
  localparam int IW    = $clog2(SETS);
  localparam int NODES = WAYS - 1;

  logic [NODES-1:0] tree [SETS];
  logic             cv;
  logic [IW-1:0]    cv_set;
  logic [WW-1:0]    pick;

  function automatic logic [WW-1:0] tree_pick(input logic [NODES-1:0] t);
    logic [WAYS-1:0] tp;
    logic [WW-1:0]   n;
    logic [WW-1:0]   w;
    tp = {1'b0, t};
    n  = '0;
    w  = '0;
    for (int l = 0; l < WW; l++) begin
      w[WW-1-l] = tp[n];
      n = WW'(2 * int'(n) + 1 + int'(tp[n]));
    end
    return w;
  endfunction

  function automatic logic [NODES-1:0] tree_mru(input logic [NODES-1:0] t,
                                               input logic [WW-1:0] w);
    logic [WAYS-1:0] tp;
    logic [WW-1:0]   n;
    tp = {1'b0, t};
    n  = '0;
    for (int l = 0; l < WW; l++) begin
      tp[n] = ~w[WW-1-l];
      n = WW'(2 * int'(n) + 1 + int'(w[WW-1-l]));
    end
    return tp[NODES-1:0];
  endfunction

  assign pick = tree_pick(tree[cv_set]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cv         <= 1'b0;
      cv_set     <= '0;
      victim_way <= '0;
      for (int s = 0; s < SETS; s++) tree[s] <= '0;
    end else begin
      cv     <= miss_req;
      cv_set <= miss_set;
      if (cv) victim_way <= pick;
      if (hit_vld)  tree[hit_set] <= tree_mru(tree[hit_set], hit_way);
      else if (cv)  tree[cv_set]  <= tree_mru(tree[cv_set], pick);
    end
  end

  AST_HIT_NOT_IN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !(hit_vld && cv)); // R6

  AST_RESET_VICTIM_ZERO: assert property (@(posedge clk)
    $past(rst) |-> victim_way == '0); // R2

  AST_VICTIM_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cv)) |-> $stable(victim_way)); // R10

  AST_BACK_TO_BACK_DIFFER: assert property (@(posedge clk) disable iff (rst)
    (cv && $past(cv) && !$past(rst) && cv_set == $past(cv_set))
      |=> victim_way != $past(victim_way)); // R8
endmodule

// File: tb/sim_plru_victim_sel.sv
module sim_plru_victim_sel;
  localparam int WAYS = 4;
  localparam int SETS = 16;
  localparam int WW = $clog2(WAYS);
  localparam int IW = $clog2(SETS);

  logic clk = 0, rst = 1, hit_vld = 0, miss_req = 0;
  logic [IW-1:0] hit_set = '0, miss_set = '0;
  logic [WW-1:0] hit_way = '0;
  logic [WW-1:0] victim_way;

  int checks = 0, errors = 0;
  bit m_tree [SETS][WAYS];
  int m_vic = 0, m_cv = 0, m_cvset = 0;

  always #4 clk = ~clk;

  plru_victim_sel #(.WAYS(WAYS), .SETS(SETS)) u0 (
    .clk(clk), .rst(rst), .hit_vld(hit_vld), .hit_set(hit_set), .hit_way(hit_way),
    .miss_req(miss_req), .miss_set(miss_set), .victim_way(victim_way));

  function automatic int m_pick(int s);
    int lo = 0, hi = WAYS, n = 0;
    while (hi - lo > 1) begin
      int mid = (lo + hi) / 2;
      if (m_tree[s][n]) begin lo = mid; n = 2*n + 2; end
      else begin hi = mid; n = 2*n + 1; end
    end
    return lo;
  endfunction

  function automatic void m_touch(int s, int w);
    int lo = 0, hi = WAYS, n = 0;
    while (hi - lo > 1) begin
      int mid = (lo + hi) / 2;
      if (w >= mid) begin m_tree[s][n] = 0; lo = mid; n = 2*n + 2; end
      else begin m_tree[s][n] = 1; hi = mid; n = 2*n + 1; end
    end
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: victim_way=%0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Drive one cycle of inputs, advance the model over the edge, compare (R7 model)
  task automatic step(bit r, bit h, int hs, int hw, bit m, int ms);
    rst = r; hit_vld = h; hit_set = IW'(hs); hit_way = WW'(hw);
    miss_req = m; miss_set = IW'(ms);
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      foreach (m_tree[s, k]) m_tree[s][k] = 0;
      m_vic = 0; m_cv = 0; m_cvset = 0;
    end else begin
      int nv = m_vic;
      if (m_cv != 0) nv = m_pick(m_cvset);
      if (h) m_touch(hs, hw);
      else if (m_cv != 0) m_touch(m_cvset, nv);
      m_vic = nv; m_cv = int'(m); m_cvset = ms;
    end
    chk("R7 per-cycle model", int'(victim_way), m_vic);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: victim_way=%0d expected run end", victim_way);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int prev;
    @(negedge clk);
    repeat (3) step(1, 0, 0, 0, 0, 0);
    chk("R2 reset victim", int'(victim_way), 0);

    step(0, 0, 0, 0, 1, 5);
    step(0, 0, 0, 0, 1, 5);
    chk("R4 capture sees old tree", int'(victim_way), 0);
    prev = int'(victim_way);
    idle();
    chk("R8 back-to-back differ", int'(victim_way != WW'(prev)), 1);
    chk("R5 first alloc protected", int'(victim_way), 2);
    step(0, 0, 0, 0, 1, 5);
    chk("R3 not yet captured", int'(victim_way), 2);
    idle();
    chk("R3 captured two edges after", int'(victim_way), 1);

    step(0, 0, 0, 0, 1, 9);
    idle();
    chk("R1 untouched set way 0", int'(victim_way), 0);

    step(0, 0, 0, 0, 1, 12); idle();
    step(0, 1, 12, 3, 0, 0);
    chk("R10 hold on hit", int'(victim_way), 0);
    step(0, 1, 12, 1, 0, 0);
    idle();
    chk("R10 hold on idle", int'(victim_way), 0);
    step(0, 0, 0, 0, 1, 12); idle();
    chk("R6 hit updates tree", int'(victim_way), 2);

    step(0, 0, 0, 0, 1, 7); idle();
    step(0, 0, 0, 0, 1, 7); idle();
    chk("R8 spaced misses differ", int'(victim_way), 2);
    repeat (3) idle();
    step(0, 1, 7, 0, 0, 0); idle();
    step(0, 0, 0, 0, 1, 7); idle();
    chk("R9 refilled and hit way protected", int'(victim_way), 3);

    for (int i = 0; i < 3000; i++) begin
      bit m = ($urandom_range(0, 2) == 0);
      bit h = (m_cv == 0) && ($urandom_range(0, 2) == 0) && !m;
      step(0, h, $urandom_range(0, 3), $urandom_range(0, WAYS-1), m,
           $urandom_range(0, 3));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule